// File: doc/BRIEF.md
# Serial Combination Lock Controller

This block controls entry to a locked room. The user keys in a secret code one bit at a time. For each bit, the user sets a two-position key switch and presses an enter button. The controller compares every keyed bit with the matching bit of a stored code. When the last bit has been keyed, it raises either an open indication or a reject indication.

A synchronous "new attempt" input starts each try. On that input the stored code is sampled from a set of code-select inputs, and the controller clears its outputs and its internal mismatch record. A mismatch on any bit is recorded silently. The controller reports it only once the full code has been keyed, so an observer cannot learn which bit was wrong. The enter button is edge-detected inside the block, so holding it down counts as a single bit. The code length is the parameter `CODE_BITS`, which defaults to three.

Top module: `serial_combo_lock`

## Requirements
- R1: After the asynchronous reset `rst_ni`, or after a cycle with `attempt_clr_i` high, both `open_o` and `reject_o` are 0.
- R2: The stored code is sampled from `code_sel_i` only in a cycle with `attempt_clr_i` high. Changes on `code_sel_i` at any other time have no effect on the outcome of the attempt in progress.
- R3: Keyed bits are compared in order. Press k (counting from 0) is compared with `code_sel_i[k]` as it was stored, so bit 0 is checked first.
- R4: A press is a 0-to-1 transition of `enter_i` between two consecutive clock edges. Holding `enter_i` high for several cycles counts as exactly one bit.
- R5: `open_o` rises on the clock edge that samples the final press, and only if every keyed bit equalled its stored bit.
- R6: `reject_o` stays 0 until the clock edge that samples the final press. It then rises if any keyed bit differed from its stored bit.
- R7: Once `open_o` or `reject_o` is 1, further presses leave both outputs unchanged until `attempt_clr_i` is asserted.
- R8: When `attempt_clr_i` and a press fall on the same edge, the clear wins and the press is not counted.
- R9: `open_o` and `reject_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| attempt_clr_i | input | 1 | Synchronous start of a new attempt; also samples the stored code |
| enter_i | input | 1 | Enter button level, active high |
| key_bit_i | input | 1 | Key switch position for the bit being keyed |
| code_sel_i | input | CODE_BITS | Stored code bits; bit 0 is compared first |
| open_o | output | 1 | Full code matched |
| reject_o | output | 1 | Attempt finished with at least one mismatch |

## Verification
The assertions assume that `enter_i` and `key_bit_i` are already synchronous to `clk_i` and free of bounce. They also assume that `key_bit_i` is steady on the edge where a press is sampled. The bench meets these assumptions by changing every input only on the falling clock edge. Every code value is paired with every keyed value, and the bench adds targeted cases: a held button, a code that changes mid-attempt, a clear that collides with a press, and presses after the attempt has finished.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_COLLECT = 2'd1,
    LK_OPEN    = 2'd2,
    LK_DENY    = 2'd3
  } lock_state_t;
endpackage

// File: rtl/lock_press_edge.sv
module lock_press_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic press_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign press_o = level_i & ~level_q;

  // R4: a press can never be reported on two consecutive edges
  p_single_press_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/lock_code_store.sv
module lock_code_store #(
  parameter int CODE_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CODE_BITS-1:0] code_i,
  output logic [CODE_BITS-1:0] code_o
);
  logic [CODE_BITS-1:0] code_q;
  logic [CODE_BITS-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (load_i) code_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  // R2: stored code only moves on a clear
  p_code_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o));
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
#(
  parameter int CODE_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 press_i,
  input  logic                 key_bit_i,
  input  logic [CODE_BITS-1:0] code_i,
  output logic                 open_o,
  output logic                 reject_o
);
  localparam int IDX_W = (CODE_BITS > 1) ? $clog2(CODE_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_BITS - 1);

  lock_state_t      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             miss_q, miss_d;
  logic             bit_ok;
  logic             at_last;
  logic             collecting;
  logic             upd_en;

  assign bit_ok     = (key_bit_i == code_i[idx_q]);
  assign at_last    = (idx_q == LAST_IDX);
  assign collecting = (state_q == LK_IDLE) || (state_q == LK_COLLECT);
  assign upd_en     = clr_i || (press_i && collecting);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    miss_d  = miss_q;
    if (clr_i) begin
      state_d = LK_IDLE;
      idx_d   = '0;
      miss_d  = 1'b0;
    end else if (press_i && collecting) begin
      miss_d = miss_q | ~bit_ok;
      if (at_last) begin
        state_d = miss_d ? LK_DENY : LK_OPEN;
        idx_d   = '0;
      end else begin
        state_d = LK_COLLECT;
        idx_d   = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_IDLE;
      idx_q   <= '0;
      miss_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      miss_q  <= miss_d;
    end
  end

  assign open_o   = (state_q == LK_OPEN);
  assign reject_o = (state_q == LK_DENY);

  // R9: outcomes are exclusive
  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && reject_o));
  // R6: reject only appears right after the final press
  p_no_early_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reject_o) |-> $past(press_i && at_last && !clr_i));
  // R5: open only appears right after the final press
  p_open_on_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(press_i && at_last && !clr_i));
  // R7: finished attempt holds until a clear
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((open_o || reject_o) && !clr_i) |=> ($stable(open_o) && $stable(reject_o)));
  // R1 / R8: clear always wins
  p_clr_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!open_o && !reject_o));
endmodule

// File: rtl/serial_combo_lock.sv
module serial_combo_lock #(
  parameter int CODE_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 attempt_clr_i,
  input  logic                 enter_i,
  input  logic                 key_bit_i,
  input  logic [CODE_BITS-1:0] code_sel_i,
  output logic                 open_o,
  output logic                 reject_o
);
  logic                 press;
  logic [CODE_BITS-1:0] code_q;

  lock_press_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (enter_i),
    .press_o (press)
  );

  lock_code_store #(.CODE_BITS(CODE_BITS)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (attempt_clr_i),
    .code_i (code_sel_i),
    .code_o (code_q)
  );

  lock_seq_fsm #(.CODE_BITS(CODE_BITS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (attempt_clr_i),
    .press_i   (press),
    .key_bit_i (key_bit_i),
    .code_i    (code_q),
    .open_o    (open_o),
    .reject_o  (reject_o)
  );
endmodule

// File: tb/serial_combo_lock_tb_top.sv
`timescale 1ns/1ps
module serial_combo_lock_tb_top;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          enter;
  logic          key;
  logic [NB-1:0] code;
  logic          open_w;
  logic          rej_w;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  serial_combo_lock #(.CODE_BITS(NB)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .attempt_clr_i (clr),
    .enter_i       (enter),
    .key_bit_i     (key),
    .code_sel_i    (code),
    .open_o        (open_w),
    .reject_o      (rej_w)
  );

  task automatic chk(input string req, input logic o_exp, input logic r_exp);
    n_run++;
    if (open_w !== o_exp || rej_w !== r_exp) begin
      n_fail++;
      $display("FAIL %s: open/reject = %b/%b expected %b/%b",
               req, open_w, rej_w, o_exp, r_exp);
    end
  endtask

  task automatic start(input logic [NB-1:0] c);
    @(negedge clk);
    clr  = 1'b1;
    code = c;
    @(negedge clk);
    clr  = 1'b0;
    code = ~c;          // R2: later changes must be ignored
  endtask

  task automatic press(input logic b);
    @(negedge clk);
    key   = b;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    enter = 1'b0;
    key   = 1'b0;
    code  = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 1'b0);

    // Exhaustive sweep: R3, R5, R6, R2
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        start(NB'(c));
        chk("R1 after clear", 1'b0, 1'b0);
        for (int i = 0; i < NB; i++) begin
          press(k[i]);
          if (i < NB - 1) chk("R6 no early outcome", 1'b0, 1'b0);
        end
        chk((c == k) ? "R5 R3 match" : "R6 R3 mismatch",
            c == k, c != k);
        // R7: extra presses do nothing
        press(~key);
        press(key);
        chk("R7 sticky", c == k, c != k);
      end
    end

    // R4: held enter counts once
    start(3'b000);
    @(negedge clk);
    key   = 1'b0;
    enter = 1'b1;
    repeat (6) @(negedge clk);
    enter = 1'b0;
    @(negedge clk);
    chk("R4 held button one bit", 1'b0, 1'b0);
    press(1'b0);
    chk("R4 second bit", 1'b0, 1'b0);
    press(1'b0);
    chk("R4 third bit opens", 1'b1, 1'b0);

    // R8: clear colliding with a press
    @(negedge clk);
    clr   = 1'b1;
    code  = 3'b101;
    key   = 1'b0;
    enter = 1'b1;
    @(negedge clk);
    clr   = 1'b0;
    enter = 1'b0;
    code  = 3'b000;
    chk("R8 clear wins", 1'b0, 1'b0);
    press(1'b1);
    press(1'b0);
    chk("R8 press not counted", 1'b0, 1'b0);
    press(1'b1);
    chk("R8 R3 full code opens", 1'b1, 1'b0);

    // R3 order: code 001, key reversed 100 must be rejected
    start(3'b001);
    press(1'b0);
    press(1'b0);
    press(1'b1);
    chk("R3 bit order", 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule